// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between an internal single-word request bus and a 32K x 8 asynchronous static RAM. A request carries a direction, a 15-bit word address and, for a store, one byte of data. The controller turns each request into the active-low chip-enable, output-enable and write-enable strobes, a held address and a split data bus. The split bus is an output value, an output enable and an input value, and a pad ring can join them into the shared pins. Read data comes back as a one-cycle response pulse.

The memory has no clock, so every interval it needs is counted in system clock cycles. Each interval is the nanosecond figure of the selected speed grade (70 ns or 100 ns) divided by the clock period and rounded up. The strobes decode straight from one state register. A single down counter times the current phase. Reads hold the address, chip enable and output enable for the full access time, then sample the input bus. Writes first wait out the output-disable float time with the bus undriven. They then pulse write enable while driving data, and end the write with write enable rising while chip enable is still low.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: Every cycle that reset is held, and the first cycle after it, chip enable, output enable and write enable are high (deselected), dq_oe is low, rsp_valid is low and req_ready is high.
- R2: req_ready is high only while the controller is idle with chip enable high. A request is taken on a clock edge where req_valid and req_ready are both high, and no second request is taken until the current one has finished.
- R3: A read (req_write = 0) holds chip enable and output enable low, write enable high and the address stable for N_RD = max(ceil(tRC/T), ceil(tOE/T)) cycles. tRC is 70/100 ns and tOE is 40/50 ns. rsp_valid rises N_RD clock edges after the accepting edge, for one cycle, and carries the byte present on dq_in at that edge. At T = 10 ns and the 70 ns grade, N_RD = 7.
- R4: A write (req_write = 1) holds write enable low for exactly N_WP = max(ceil(55/T), ceil(35/T), ceil(65/T) - N_TA) cycles on the 70 ns grade (75, 40, 90 ns on the 100 ns grade). Chip enable is low and output enable is high throughout. At T = 10 ns and the 70 ns grade, N_WP = 6.
- R5: dq_oe is high only while chip enable is low and output enable is high. It stays high from the fall of write enable through the cycle in which write enable rises, so data hold at the terminating edge is at least one cycle.
- R6: Write data is never driven, and write enable never falls, until output enable has been high for at least N_TA = ceil(tOHZ/T) cycles (30/35 ns; N_TA = 3 at 10 ns). This holds even when the write follows a read with no gap.
- R7: sram_addr changes only while write enable is high and was high in the cycle before. It changes only on an accepting edge.
- R8: A write ends with write enable rising while chip enable is still low. Chip enable stays low for N_REC = max(ceil(tWR/T), ceil(tWC/T) - N_TA - N_WP, 1) recovery cycles after that, and the accepting edge to return to idle spans at least ceil(tWC/T) cycles.
- R9: With no request pending, chip enable and output enable stay high and dq_oe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = store byte, 0 = fetch byte |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Byte to store |
| rsp_valid | output | 1 | One-cycle pulse marking returned read data |
| rsp_rdata | output | DATA_W | Returned read byte |
| sram_ce_n | output | 1 | Chip enable to the memory, active low |
| sram_oe_n | output | 1 | Output enable to the memory, active low |
| sram_we_n | output | 1 | Write enable to the memory, active low |
| sram_addr | output | ADDR_W | Address to the memory |
| dq_out | output | DATA_W | Value for the data pins when driven |
| dq_oe | output | 1 | Drive enable for the data pins |
| dq_in | input | DATA_W | Value sensed on the data pins |

## Verification
The bound checker watches the strobe relations on every cycle. Write enable must not be low unless chip enable is low and output enable is high. The bus must not be driven while the memory may be driving. The address must not move near a write pulse. The checker also counts the float time before any drive and the length of every write pulse. Whether a read returns the right byte after the full access time, and whether a written byte can be read back, only the bench scenarios can show. They use a memory model that returns a wrong value when it is sampled early and commits data only on the terminating edge. The same holds for the exact response latency and for a read followed at once by a write.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WSETUP,
      ST_WPULSE,
      ST_WRECOV
   } sram_state_e;

   // nanoseconds to whole clock cycles, rounded up, never below one
   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      int c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sram_interval_timer.sv
module sram_interval_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int N_RD  = 7,
   parameter int N_TA  = 3,
   parameter int N_WP  = 6,
   parameter int N_REC = 1,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             expired,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output logic             accept,
   output logic             capture,
   output logic             req_ready,
   output logic             ce_n,
   output logic             oe_n,
   output logic             we_n,
   output logic             dq_oe
);

   localparam logic [CNT_W-1:0] LD_RD  = CNT_W'(N_RD - 1);
   localparam logic [CNT_W-1:0] LD_TA  = CNT_W'(N_TA - 1);
   localparam logic [CNT_W-1:0] LD_WP  = CNT_W'(N_WP - 1);
   localparam logic [CNT_W-1:0] LD_REC = CNT_W'(N_REC - 1);

   sram_state_e state_q, state_d;

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   always_comb begin
      state_d  = state_q;
      load     = 1'b0;
      load_val = '0;
      accept   = 1'b0;
      capture  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               accept = 1'b1;
               load   = 1'b1;
               if (req_write) begin
                  state_d  = ST_WSETUP;
                  load_val = LD_TA;
               end else begin
                  state_d  = ST_READ;
                  load_val = LD_RD;
               end
            end
         end
         ST_READ: begin
            if (expired) begin
               capture = 1'b1;
               state_d = ST_IDLE;
            end
         end
         ST_WSETUP: begin
            if (expired) begin
               state_d  = ST_WPULSE;
               load     = 1'b1;
               load_val = LD_WP;
            end
         end
         ST_WPULSE: begin
            if (expired) begin
               state_d  = ST_WRECOV;
               load     = 1'b1;
               load_val = LD_REC;
            end
         end
         ST_WRECOV: begin
            if (expired) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   // strobes decode from the state register only
   always_comb begin
      req_ready = (state_q == ST_IDLE);
      ce_n      = (state_q == ST_IDLE);
      oe_n      = (state_q != ST_READ);
      we_n      = (state_q != ST_WPULSE);
      dq_oe     = (state_q == ST_WPULSE) || (state_q == ST_WRECOV);
   end

endmodule

// File: rtl/sram_bus_regs.sv
module sram_bus_regs #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] dq_in,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [DATA_W-1:0] dq_out,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);

   always_ff @(posedge clk) begin
      if (rst) begin
         sram_addr <= '0;
         dq_out    <= '0;
      end else if (accept) begin
         sram_addr <= req_addr;
         dq_out    <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= capture;
         if (capture) rsp_rdata <= dq_in;
      end
   end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int CLK_PERIOD_NS  = 10,
   parameter int SPEED_GRADE_NS = 70,
   parameter int ADDR_W         = 15,
   parameter int DATA_W         = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              sram_ce_n,
   output logic              sram_oe_n,
   output logic              sram_we_n,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   input  logic [DATA_W-1:0] dq_in
);

   localparam bit G70 = (SPEED_GRADE_NS == 70);

   // grade figures in ns
   localparam int T_RC  = G70 ? 70 : 100;
   localparam int T_OE  = G70 ? 40 : 50;
   localparam int T_WC  = G70 ? 70 : 100;
   localparam int T_CW  = G70 ? 65 : 90;
   localparam int T_WP  = G70 ? 55 : 75;
   localparam int T_DW  = G70 ? 35 : 40;
   localparam int T_WR  = 5;
   localparam int T_OHZ = G70 ? 30 : 35;

   // cycle counts
   localparam int N_RD  = max3(ns_to_cyc(T_RC, CLK_PERIOD_NS),
                               ns_to_cyc(T_OE, CLK_PERIOD_NS), 1);
   localparam int N_TA  = ns_to_cyc(T_OHZ, CLK_PERIOD_NS);
   localparam int N_WP  = max3(ns_to_cyc(T_WP, CLK_PERIOD_NS),
                               ns_to_cyc(T_DW, CLK_PERIOD_NS),
                               ns_to_cyc(T_CW, CLK_PERIOD_NS) - N_TA);
   localparam int N_REC = max3(ns_to_cyc(T_WR, CLK_PERIOD_NS),
                               ns_to_cyc(T_WC, CLK_PERIOD_NS) - N_TA - N_WP, 1);
   localparam int N_MAX = max3(max3(N_RD, N_TA, N_WP), N_REC, 2);
   localparam int CNT_W = $clog2(N_MAX);

   generate
      if (SPEED_GRADE_NS != 70 && SPEED_GRADE_NS != 100) begin : g_bad_grade
         $error("SPEED_GRADE_NS must be 70 or 100");
      end
      if (CLK_PERIOD_NS < 1) begin : g_bad_clk
         $error("CLK_PERIOD_NS must be positive");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ADDR_W and DATA_W must be positive");
      end
   endgenerate

   logic             load;
   logic [CNT_W-1:0] load_val;
   logic             expired;
   logic             accept;
   logic             capture;

   sram_interval_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .load_val (load_val),
      .expired  (expired)
   );

   sram_cycle_fsm #(
      .N_RD  (N_RD),
      .N_TA  (N_TA),
      .N_WP  (N_WP),
      .N_REC (N_REC),
      .CNT_W (CNT_W)
   ) i_fsm (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .req_write (req_write),
      .expired   (expired),
      .load      (load),
      .load_val  (load_val),
      .accept    (accept),
      .capture   (capture),
      .req_ready (req_ready),
      .ce_n      (sram_ce_n),
      .oe_n      (sram_oe_n),
      .we_n      (sram_we_n),
      .dq_oe     (dq_oe)
   );

   sram_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
      .clk       (clk),
      .rst       (rst),
      .accept    (accept),
      .capture   (capture),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .dq_in     (dq_in),
      .sram_addr (sram_addr),
      .dq_out    (dq_out),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
   parameter int ADDR_W = 15,
   parameter int N_TA   = 3,
   parameter int N_WP   = 6
) (
   input logic              clk,
   input logic              rst,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              sram_ce_n,
   input logic              sram_oe_n,
   input logic              sram_we_n,
   input logic [ADDR_W-1:0] sram_addr,
   input logic              dq_oe
);

   logic [15:0] oe_hi_cnt;
   logic [15:0] we_lo_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         oe_hi_cnt <= '0;
         we_lo_cnt <= '0;
      end else begin
         if (!sram_oe_n)             oe_hi_cnt <= '0;
         else if (oe_hi_cnt != '1)   oe_hi_cnt <= oe_hi_cnt + 1'b1;
         if (sram_we_n)              we_lo_cnt <= '0;
         else if (we_lo_cnt != '1)   we_lo_cnt <= we_lo_cnt + 1'b1;
      end
   end

   AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (sram_ce_n && sram_we_n && !dq_oe)); // R2

   AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |=> !rsp_valid); // R3

   AST_WE_IN_SELECT: assert property (@(posedge clk) disable iff (rst)
      !sram_we_n |-> (!sram_ce_n && sram_oe_n)); // R4

   AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
      $rose(sram_we_n) |-> (32'(we_lo_cnt) >= N_WP)); // R4

   AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
      dq_oe |-> (sram_oe_n && !sram_ce_n)); // R5

   AST_FLOAT_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (rst)
      $rose(dq_oe) |-> (32'(oe_hi_cnt) >= N_TA)); // R6

   AST_ADDR_UNDER_WE_HIGH: assert property (@(posedge clk) disable iff (rst)
      !$stable(sram_addr) |-> (sram_we_n && $past(sram_we_n))); // R7

   AST_WRITE_ENDS_ON_WE: assert property (@(posedge clk) disable iff (rst)
      $rose(sram_we_n) |-> (!sram_ce_n && dq_oe)); // R8

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .N_TA   (N_TA),
   .N_WP   (N_WP)
) i_chk (
   .clk       (clk),
   .rst       (rst),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .sram_ce_n (sram_ce_n),
   .sram_oe_n (sram_oe_n),
   .sram_we_n (sram_we_n),
   .sram_addr (sram_addr),
   .dq_oe     (dq_oe)
);

// File: tb/test_sram_cycle_ctrl.sv
module test_sram_cycle_ctrl;

   localparam int CLK_NS  = 10;
   localparam int AW      = 15;
   localparam int DW      = 8;
   // expected counts at 10 ns, 70 ns grade, from the requirements
   localparam int EXP_RD  = 7;   // R3
   localparam int EXP_TA  = 3;   // R6
   localparam int EXP_WP  = 6;   // R4
   localparam int EXP_WC  = 7;   // R8

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          ce_n, oe_n, we_n, dq_oe;
   logic [AW-1:0] sram_addr;
   logic [DW-1:0] dq_out;
   logic [DW-1:0] dq_in = '0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 0;

   always #(CLK_NS/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sram_cycle_ctrl #(.CLK_PERIOD_NS(CLK_NS), .SPEED_GRADE_NS(70)) i_sram_cycle_ctrl (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .sram_ce_n(ce_n), .sram_oe_n(oe_n), .sram_we_n(we_n),
      .sram_addr(sram_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
      return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
   endfunction

   // ---------------- memory model ----------------
   logic [DW-1:0] mem [int];
   logic [DW-1:0] refmem [int];

   function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
      return mem.exists(int'(a)) ? mem[int'(a)] : init_val(a);
   endfunction

   int            rd_age = 0;
   bit            rd_on = 0;
   logic [AW-1:0] prev_addr = '0;
   bit            prev_we = 1;
   int            we_low = 0;
   int            oe_high = 0;
   bit            prev_dq_oe = 0;
   logic [DW-1:0] wr_latch = '0;
   int            addr_viol = 0;
   int            ready_viol = 0;

   always @(negedge clk) begin
      if (!rst) begin
         // read access age: returns the stored byte only once the full access time has elapsed
         if (!ce_n && !oe_n && we_n) begin
            if (rd_on && sram_addr == prev_addr) rd_age++;
            else rd_age = 0;
            rd_on = 1;
         end else begin
            rd_on = 0;
            rd_age = 0;
         end
         dq_in <= (rd_on && (rd_age + 1) * CLK_NS >= 70) ? mem_rd(sram_addr) : ~mem_rd(sram_addr);

         // R6: float time before first drive
         if (dq_oe && !prev_dq_oe)
            check(oe_high - 1 >= EXP_TA, "R6 float cycles before drive", oe_high - 1, EXP_TA);
         if (!oe_n) oe_high = 0; else oe_high++;

         // write tracking
         if (!we_n && !ce_n) begin
            we_low++;
            wr_latch = dq_out;
         end else if (we_n && !prev_we) begin
            check(we_low == EXP_WP, "R4 write pulse length", we_low, EXP_WP);
            check(!ce_n && dq_oe, "R8 write ends on WE with CE low and data held", {ce_n, dq_oe}, 2'b01);
            mem[int'(sram_addr)] = wr_latch;
            we_low = 0;
         end

         // R7 and R2 observations
         if (sram_addr != prev_addr && (!we_n || !prev_we)) addr_viol++;
         if (req_ready && !ce_n) ready_viol++;
         if (dq_oe && !oe_n) ready_viol++;

         prev_addr  = sram_addr;
         prev_we    = we_n;
         prev_dq_oe = dq_oe;
      end
   end

   // ---------------- scoreboard ----------------
   logic [DW-1:0] exp_q [$];
   int            acc_q [$];

   always @(negedge clk) begin
      if (!rst && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check(0, "R3 unexpected response", rsp_rdata, 0);
         end else begin
            automatic logic [DW-1:0] e = exp_q.pop_front();
            automatic int a = acc_q.pop_front();
            check(rsp_rdata == e, "R3 read data", rsp_rdata, e);
            check(cyc - a == EXP_RD, "R3 response latency", cyc - a, EXP_RD);
         end
      end
   end

   // ---------------- driver ----------------
   task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      int acc;
      int tstart;
      req_valid = 1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      acc = cyc;
      req_valid = 0;
      check(!req_ready, "R2 ready drops after accept", req_ready, 0);
      if (wr) begin
         refmem[int'(a)] = d;
         tstart = acc;
         while (!req_ready) @(negedge clk);
         check(cyc - tstart >= EXP_WC, "R8 write cycle length", cyc - tstart, EXP_WC);
      end else begin
         exp_q.push_back(refmem.exists(int'(a)) ? refmem[int'(a)] : init_val(a));
         acc_q.push_back(acc);
      end
   endtask

   task automatic drain();
      while (exp_q.size() != 0 || !req_ready) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_NS * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: during reset
      check(ce_n && oe_n && we_n, "R1 strobes high in reset", {ce_n, oe_n, we_n}, 3'b111);
      check(!dq_oe && !rsp_valid && req_ready, "R1 bus idle in reset", {dq_oe, rsp_valid, req_ready}, 3'b001);
      rst = 0;
      @(negedge clk);
      check(ce_n && oe_n && we_n && !dq_oe, "R1 first cycle after reset", {ce_n, oe_n, we_n, dq_oe}, 4'b1110);

      // R9: idle with no request
      begin
         int bad = 0;
         for (int i = 0; i < 10; i++) begin
            if (!ce_n || !oe_n || dq_oe) bad++;
            @(negedge clk);
         end
         check(bad == 0, "R9 idle strobes", bad, 0);
      end

      // R3: reads of initial contents, boundary addresses
      do_req(0, 15'h0000, 8'h00);
      do_req(0, 15'h7FFF, 8'h00);
      do_req(0, 15'h1234, 8'h00);
      drain();

      // R4/R8: writes then read back
      do_req(1, 15'h0010, 8'hA5);
      do_req(0, 15'h0010, 8'h00);
      do_req(1, 15'h7FFF, 8'h3C);
      do_req(0, 15'h7FFF, 8'h00);
      drain();

      // R6: read followed at once by write, then read back
      do_req(0, 15'h0020, 8'h00);
      do_req(1, 15'h0020, 8'hC3);
      do_req(0, 15'h0020, 8'h00);
      do_req(1, 15'h0000, 8'hFF);
      do_req(1, 15'h0001, 8'h00);
      do_req(0, 15'h0000, 8'h00);
      do_req(0, 15'h0001, 8'h00);
      drain();

      // R9 again after traffic
      begin
         int bad = 0;
         for (int i = 0; i < 10; i++) begin
            if (!ce_n || !oe_n || dq_oe || rsp_valid) bad++;
            @(negedge clk);
         end
         check(bad == 0, "R9 idle after traffic", bad, 0);
      end

      check(addr_viol == 0, "R7 address moved near write pulse", addr_viol, 0);
      check(ready_viol == 0, "R2 R5 ready or drive while bus busy", ready_viol, 0);
      check(exp_q.size() == 0, "R3 responses outstanding", exp_q.size(), 0);
      finish_run();
   end

endmodule